// File: doc/BRIEF.md
# ROM Table Lookup Pointer Unit

This block holds a 12-bit pointer into an 8-bit-wide program ROM of 3072 words and returns constant data from that ROM one 4-bit nibble at a time. A controller assembles the pointer with three nibble writes, for bits 3:0, 7:4 and 11:8, in any order. It then issues read strobes. A low read returns bits 3:0 of the addressed word and leaves the pointer where it is. A high read returns bits 7:4 and then advances the pointer by one, so a table of bytes can be walked with alternating low and high reads.

The ROM is synchronous, with one cycle of latency. The pointer is always visible on the ROM address port. A request is raised in the same cycle as the strobe, and the nibble appears on the data output one cycle later together with a valid flag. Addresses beyond the populated ROM range read as zero, and no ROM access is made for them.

Top module: `tbl_ptr_unit`

## Requirements
- R1: While reset is high (synchronous, active high), and in the first cycle after it, the pointer is 000h, as seen on `rom_addr_o`. `nib_vld_o` is low during reset.
- R2: When `wr_en_i` bit 0, 1 or 2 is set, pointer bits 3:0, 7:4 or 11:8 respectively take `wr_data_i` at the clock edge. Unselected parts keep their value. Several bits may be set together.
- R3: A low read (`rd_lo_i`) returns bits 3:0 of ROM[pointer] on `nib_o` in the next cycle, and the pointer does not change.
- R4: A high read (`rd_hi_i`) returns bits 7:4 of ROM[pointer] on `nib_o` in the next cycle. The pointer increments by one at the strobe's clock edge.
- R5: A high read with the pointer at FFFh leaves the pointer at 000h.
- R6: When a read is strobed with the pointer at or above C00h, `rom_rd_o` stays low and the next cycle shows `nib_o` = 0 with `nib_vld_o` high. The pointer still increments on a high read.
- R7: A high read in the same cycle as any nibble write applies the write and drops the increment. The read uses the pointer value from before the write.
- R8: When `rd_lo_i` and `rd_hi_i` are both high, the access is a high read.
- R9: `rom_rd_o` is high exactly in strobe cycles whose pointer is below C00h. `nib_vld_o` is high exactly in the cycle after a strobe. `nib_o` is 0 whenever `nib_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 3 | Nibble write selects (bit0 low, bit1 middle, bit2 high) |
| wr_data_i | input | 4 | Nibble written into the selected parts |
| rd_lo_i | input | 1 | Low-nibble read strobe |
| rd_hi_i | input | 1 | High-nibble read strobe with post-increment |
| rom_addr_o | output | 12 | Current pointer, used as the ROM address |
| rom_rd_o | output | 1 | ROM read request |
| rom_data_i | input | 8 | ROM word, valid one cycle after the request |
| nib_o | output | 4 | Returned nibble |
| nib_vld_o | output | 1 | Nibble valid |

## Verification
The bench builds the block with its default parameters: a 12-bit pointer, 4-bit nibbles and 3072 ROM words. With these values the pointer can reach both FFFh and the C00h boundary, so the bench exercises the wrap, the last populated word BFFh and the first empty address. It also covers the known word at 777h, a write colliding with a high read, and both strobes raised together. Random traffic then mixes these cases, and a bench model of the ROM answers with one cycle of latency.

// File: rtl/tbl_ptr_pkg.sv
package tbl_ptr_pkg;

    localparam int unsigned DEF_NIB_W     = 4;
    localparam int unsigned DEF_PTR_W     = 12;
    localparam int unsigned DEF_ROM_WORDS = 3072;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_LO   = 2'd1,
        RD_HI   = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic     vld;
        rd_kind_e kind;
        logic     oor;
    } rd_tag_t;

    function automatic logic in_rom(input int unsigned addr, input int unsigned words);
        return addr < words;
    endfunction

    function automatic rd_kind_e pick_kind(input logic lo, input logic hi);
        if (hi)      return RD_HI;
        else if (lo) return RD_LO;
        else         return RD_NONE;
    endfunction

endpackage

// File: rtl/tbl_ptr_reg.sv
module tbl_ptr_reg #(
    parameter int unsigned PTR_W = tbl_ptr_pkg::DEF_PTR_W,
    parameter int unsigned NIB_W = tbl_ptr_pkg::DEF_NIB_W,
    localparam int unsigned PARTS = PTR_W / NIB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PARTS-1:0] wr_en_i,
    input  logic [NIB_W-1:0] wr_data_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] ptr_o
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic             any_wr;

    assign ptr_inc = ptr_q + PTR_W'(1);
    assign any_wr  = |wr_en_i;
    assign ptr_o   = ptr_q;

    for (genvar g = 0; g < PARTS; g++) begin : g_part
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[g*NIB_W +: NIB_W] <= '0;
            else if (wr_en_i[g])
                ptr_q[g*NIB_W +: NIB_W] <= wr_data_i;
            else if (inc_i && !any_wr)
                ptr_q[g*NIB_W +: NIB_W] <= ptr_inc[g*NIB_W +: NIB_W];
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !any_wr) |=> $stable(ptr_q));
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !any_wr) |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));
    p_low_part_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i[0] |=> ptr_q[NIB_W-1:0] == $past(wr_data_i));
    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !wr_en_i[0] && any_wr) |=> ptr_q[NIB_W-1:0] == $past(ptr_q[NIB_W-1:0]));

endmodule

// File: rtl/tbl_rd_ctrl.sv
module tbl_rd_ctrl
    import tbl_ptr_pkg::*;
#(
    parameter int unsigned PTR_W     = DEF_PTR_W,
    parameter int unsigned ROM_WORDS = DEF_ROM_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic             rom_rd_o,
    output logic             inc_o,
    output rd_tag_t          tag_o
);

    rd_kind_e kind;
    logic     oor;
    rd_tag_t  tag_q;

    assign kind     = pick_kind(rd_lo_i, rd_hi_i);
    assign oor      = !in_rom(32'(ptr_i), ROM_WORDS);
    assign rom_rd_o = (kind != RD_NONE) && !oor;
    assign inc_o    = (kind == RD_HI);
    assign tag_o    = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '{vld: 1'b0, kind: RD_NONE, oor: 1'b0};
        end else begin
            tag_q.vld  <= (kind != RD_NONE);
            tag_q.kind <= kind;
            tag_q.oor  <= oor;
        end
    end

    p_no_empty_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (32'(ptr_i) >= ROM_WORDS) |-> !rom_rd_o);
    p_hi_priority_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_lo_i && rd_hi_i) |=> tag_q.kind == RD_HI);

endmodule

// File: rtl/tbl_nib_sel.sv
module tbl_nib_sel
    import tbl_ptr_pkg::*;
#(
    parameter int unsigned NIB_W = DEF_NIB_W,
    localparam int unsigned WORD_W = 2 * NIB_W
) (
    input  rd_tag_t           tag_i,
    input  logic [WORD_W-1:0] rom_data_i,
    output logic [NIB_W-1:0]  nib_o,
    output logic              vld_o
);

    always_comb begin
        nib_o = '0;
        if (tag_i.vld && !tag_i.oor) begin
            if (tag_i.kind == RD_HI)
                nib_o = rom_data_i[WORD_W-1:NIB_W];
            else
                nib_o = rom_data_i[NIB_W-1:0];
        end
    end

    assign vld_o = tag_i.vld;

endmodule

// File: rtl/tbl_ptr_unit.sv
module tbl_ptr_unit
    import tbl_ptr_pkg::*;
#(
    parameter int unsigned PTR_W     = DEF_PTR_W,
    parameter int unsigned NIB_W     = DEF_NIB_W,
    parameter int unsigned ROM_WORDS = DEF_ROM_WORDS,
    localparam int unsigned PARTS    = PTR_W / NIB_W,
    localparam int unsigned WORD_W   = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PARTS-1:0]  wr_en_i,
    input  logic [NIB_W-1:0]  wr_data_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    output logic [PTR_W-1:0]  rom_addr_o,
    output logic              rom_rd_o,
    input  logic [WORD_W-1:0] rom_data_i,
    output logic [NIB_W-1:0]  nib_o,
    output logic              nib_vld_o
);

    logic    inc;
    rd_tag_t tag;

    tbl_ptr_reg #(.PTR_W(PTR_W), .NIB_W(NIB_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .inc_i     (inc),
        .ptr_o     (rom_addr_o)
    );

    tbl_rd_ctrl #(.PTR_W(PTR_W), .ROM_WORDS(ROM_WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_lo_i  (rd_lo_i),
        .rd_hi_i  (rd_hi_i),
        .ptr_i    (rom_addr_o),
        .rom_rd_o (rom_rd_o),
        .inc_o    (inc),
        .tag_o    (tag)
    );

    tbl_nib_sel #(.NIB_W(NIB_W)) u_sel (
        .tag_i      (tag),
        .rom_data_i (rom_data_i),
        .nib_o      (nib_o),
        .vld_o      (nib_vld_o)
    );

    p_vld_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_lo_i || rd_hi_i) |=> nib_vld_o);
    p_vld_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_lo_i || rd_hi_i) |=> !nib_vld_o);
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !nib_vld_o |-> nib_o == '0);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> rom_addr_o == '0 && !nib_vld_o);

endmodule

// File: tb/test_tbl_ptr_unit.sv
module test_tbl_ptr_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] wr_en = '0;
    logic [3:0] wr_data = '0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [11:0] rom_addr;
    logic       rom_rd;
    logic [7:0] rom_q;
    logic [3:0] nib;
    logic       nib_vld;

    int checks = 0;
    int fails  = 0;
    logic [11:0] mptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbl_ptr_unit i_tbl_ptr_unit (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .rom_addr_o(rom_addr),
        .rom_rd_o(rom_rd), .rom_data_i(rom_q), .nib_o(nib), .nib_vld_o(nib_vld)
    );

    function automatic logic [7:0] rom_f(input logic [11:0] a);
        if (a == 12'h777) return 8'h56;
        return (a[7:0] * 8'd13) ^ {a[11:8], a[3:0]} ^ 8'hA5;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) rom_q <= '0;
        else if (rom_rd) rom_q <= rom_f(rom_addr);
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [2:0] we, input logic [3:0] wd,
                        input logic lo, input logic hi);
        logic       ev;
        logic [3:0] en;
        logic [7:0] w;
        wr_en = we; wr_data = wd; rd_lo = lo; rd_hi = hi;
        #1;
        chk(tag, rom_addr, mptr, "rom_addr");
        chk(tag, rom_rd, (lo | hi) && mptr < 12'hC00, "rom_rd");
        ev = lo | hi;
        w  = rom_f(mptr);
        en = !ev ? 4'h0 : (mptr >= 12'hC00) ? 4'h0 : hi ? w[7:4] : w[3:0];
        if (we != 0) begin
            if (we[0]) mptr[3:0]  = wd;
            if (we[1]) mptr[7:4]  = wd;
            if (we[2]) mptr[11:8] = wd;
        end else if (hi) begin
            mptr = mptr + 12'd1;
        end
        @(posedge clk); @(negedge clk);
        chk(tag, nib_vld, ev, "nib_vld");
        chk(tag, nib, en, "nib");
        chk(tag, rom_addr, mptr, "pointer after edge");
    endtask

    task automatic load(input string tag, input logic [11:0] v);
        step(tag, 3'b001, v[3:0], 1'b0, 1'b0);
        step(tag, 3'b010, v[7:4], 1'b0, 1'b0);
        step(tag, 3'b100, v[11:8], 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        mptr = '0;
        repeat (3) @(negedge clk);
        chk("R1", rom_addr, 0, "addr in reset");
        chk("R1", nib_vld, 0, "vld in reset");
        rst = 1'b0;
        step("R1", 3'b000, 4'h0, 1'b1, 1'b0);
        step("R9", 3'b000, 4'h0, 1'b0, 1'b0);
        step("R2", 3'b111, 4'h7, 1'b0, 1'b0);
        step("R3", 3'b000, 4'h0, 1'b1, 1'b0);
        step("R4", 3'b000, 4'h0, 1'b0, 1'b1);
        step("R2", 3'b010, 4'hA, 1'b0, 1'b0);
        load("R5", 12'hFFF);
        step("R5", 3'b000, 4'h0, 1'b0, 1'b1);
        load("R6", 12'hBFF);
        step("R6", 3'b000, 4'h0, 1'b0, 1'b1);
        step("R6", 3'b000, 4'h0, 1'b1, 1'b0);
        step("R6", 3'b000, 4'h0, 1'b0, 1'b1);
        load("R7", 12'h3A4);
        step("R7", 3'b001, 4'h9, 1'b0, 1'b1);
        step("R7", 3'b100, 4'h1, 1'b0, 1'b1);
        step("R8", 3'b000, 4'h0, 1'b1, 1'b1);
        step("R8", 3'b000, 4'h0, 1'b1, 1'b1);
        for (int i = 0; i < 400; i++) begin
            logic [2:0] we;
            we = ($urandom % 5 == 0) ? 3'($urandom) : 3'b000;
            step("R3", we, 4'($urandom), 1'($urandom), 1'($urandom));
        end
        step("R9", 3'b000, 4'h0, 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule